// File: doc/BRIEF.md
# Banked Instruction Fetch Memory

This block is the instruction store of a small stack processor. It delivers one 9-bit opcode per clock from a read-only program memory, addressed by the program counter. The program space is split into equal-sized banks. The high program-counter bits pick a bank, and the low bits pick a word inside it. A program-counter value whose bank number has no memory behind it fetches a zero opcode.

Memory words may be wider than the opcode. Any bits above bit 8 are read with the word and then dropped. The contents are built at elaboration from a fixed program pattern. Words past the end of the program are filled with zeros, or with a computed pseudo-random 9-bit pattern when that option is chosen. The opcode register adds one cycle of latency. The block also decodes the push-constant form of the opcode for the stage that follows it.

Top module: `fetch_rom`

## Requirements
- R1: The opcode register holds 9'h000 at power-up, before any clock edge.
- R2: On a rising edge with `rst` high, the opcode register loads 9'h000 whatever the `pc`.
- R3: On a rising edge with `rst` low, `opcode` takes the word stored at the `pc` present at that edge. It is visible one cycle after the address was applied. The bank number is `pc[PC_W-1:BLK_BITS]`, the offset is `pc[BLK_BITS-1:0]`, and the linear address is bank*BLOCK_WORDS + offset.
- R4: A bank number of NUM_BLOCKS or more (bank 3 with the default parameters) fetches 9'h000.
- R5: Each stored word is WORD_W bits wide, with the opcode in bits [8:0]. For programmed and pseudo-random words, every bit above bit 8 is 1. These bits never appear on `opcode`.
- R6: `is_push` equals `opcode` bit 8. `push_imm` equals `opcode[7:0]` when `is_push` is 1, and 8'h00 otherwise.
- R7: For linear address a < PROG_LEN, the stored opcode is (a*37 + 5) mod 512.
- R8: For a >= PROG_LEN, the whole stored word is zero when FILL_RANDOM is 0. When FILL_RANDOM is 1, the stored opcode is (a*(a+3) + 11) mod 512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pc | input | PC_W | Program counter (bank number in high bits, offset in low bits) |
| opcode | output | 9 | Registered opcode |
| is_push | output | 1 | Opcode is a push-constant instruction |
| push_imm | output | 8 | Immediate of a push-constant opcode, zero otherwise |

## Verification
A wrong bank decode or offset slice shows up on the first fetch at the affected address. It appears one cycle after the address is applied, as an opcode from another bank or from another offset. Every address is therefore swept in order, which crosses each bank boundary, and random addresses are then applied. A leaked upper word bit or a missed unmapped bank appears as a nonzero opcode on the very next cycle. A reset that fails to clear shows up in the cycle after `rst` rises.

// File: rtl/fetch_rom.sv
module fetch_rom #(
  parameter int BLOCK_WORDS = 64,
  parameter int NUM_BLOCKS  = 3,
  parameter int WORD_W      = 12,
  parameter int PROG_LEN    = 150,
  parameter bit FILL_RANDOM = 1'b0,
  localparam int BLK_BITS   = $clog2(BLOCK_WORDS),
  localparam int PC_W       = $clog2(NUM_BLOCKS * BLOCK_WORDS),
  localparam int SEL_BITS   = PC_W - BLK_BITS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] pc,
  output logic [8:0]      opcode,
  output logic            is_push,
  output logic [7:0]      push_imm
);

  function automatic logic [WORD_W-1:0] init_word(input int a);
    logic [WORD_W-1:0] w;
    w = '1;
    if (a < PROG_LEN)
      w[8:0] = 9'((a * 37 + 5) % 512);
    else if (FILL_RANDOM)
      w[8:0] = 9'((a * (a + 3) + 11) % 512);
    else
      w = '0;
    return w;
  endfunction

  logic [WORD_W-1:0] blk_rd [NUM_BLOCKS];
  logic [WORD_W-1:0] sel_word;
  logic [8:0]        opcode_q = 9'h000;

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_bank
    logic [WORD_W-1:0] mem [BLOCK_WORDS];
    initial begin
      for (int i = 0; i < BLOCK_WORDS; i++)
        mem[i] = init_word(b * BLOCK_WORDS + i);
    end
    assign blk_rd[b] = mem[pc[BLK_BITS-1:0]];
  end

  if (SEL_BITS == 0) begin : g_single
    assign sel_word = blk_rd[0];
  end else begin : g_multi
    always_comb begin
      sel_word = '0;
      for (int b = 0; b < NUM_BLOCKS; b++)
        if (pc[PC_W-1 -: SEL_BITS] == SEL_BITS'(b))
          sel_word = blk_rd[b];
    end
  end

  if (WORD_W > 9) begin : g_wide
    logic [WORD_W-10:0] unused_hi;
    assign unused_hi = sel_word[WORD_W-1:9];
  end

  always_ff @(posedge clk)
    if (rst) opcode_q <= 9'h000;
    else     opcode_q <= sel_word[8:0];

  assign opcode   = opcode_q;
  assign is_push  = opcode_q[8];
  assign push_imm = opcode_q[8] ? opcode_q[7:0] : 8'h00;

endmodule

module fetch_rom_chk #(
  parameter int NUM_BLOCKS = 3,
  parameter int PC_W       = 8,
  parameter int BLK_BITS   = 6
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] pc,
  input logic [8:0]      opcode,
  input logic            is_push,
  input logic [7:0]      push_imm
);

  initial a_r1_powerup_zero: assert (opcode == 9'h000);

  a_r2_reset_clears: assert property (@(posedge clk)
    rst |=> opcode == 9'h000);

  a_r4_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    ((pc >> BLK_BITS) >= PC_W'(NUM_BLOCKS)) |=> opcode == 9'h000);

  a_r3_same_pc_same_opcode: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && pc == $past(pc)) |=> $stable(opcode));

  a_r6_no_imm_without_push: assert property (@(posedge clk)
    !is_push |-> push_imm == 8'h00);

endmodule

bind fetch_rom fetch_rom_chk #(.NUM_BLOCKS(NUM_BLOCKS), .PC_W(PC_W), .BLK_BITS(BLK_BITS))
  u_chk (.clk(clk), .rst(rst), .pc(pc), .opcode(opcode), .is_push(is_push), .push_imm(push_imm));

// File: tb/fetch_rom_tb.sv
module fetch_rom_tb;
  localparam int BW = 64, NB = 3, PL = 150, PCW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PCW-1:0] pc = '0;
  logic [8:0] op0, op1;
  logic push0, push1;
  logic [7:0] imm0, imm1;
  int nvec = 0, nerr = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fetch_rom #(.BLOCK_WORDS(BW), .NUM_BLOCKS(NB), .WORD_W(12), .PROG_LEN(PL), .FILL_RANDOM(1'b0))
    u_dut (.clk(clk), .rst(rst), .pc(pc), .opcode(op0), .is_push(push0), .push_imm(imm0));
  fetch_rom #(.BLOCK_WORDS(BW), .NUM_BLOCKS(NB), .WORD_W(12), .PROG_LEN(PL), .FILL_RANDOM(1'b1))
    u_dut_rnd (.clk(clk), .rst(rst), .pc(pc), .opcode(op1), .is_push(push1), .push_imm(imm1));

  function automatic logic [8:0] exp_op(input int a, input bit rnd);
    if (a / BW >= NB) return 9'h000;
    if (a < PL) return 9'((a * 37 + 5) % 512);
    if (rnd) return 9'((a * (a + 3) + 11) % 512);
    return 9'h000;
  endfunction

  task automatic check(input string tag, input int got, input int expv);
    nvec++;
    if (got != expv) begin
      nerr++;
      $display("FAIL %s: got %0h expected %0h", tag, got, expv);
    end
  endtask

  task automatic check_all(input string tag, input int a);
    logic [8:0] e0, e1;
    e0 = exp_op(a, 1'b0);
    e1 = exp_op(a, 1'b1);
    check({tag, " R3 R5 R7 R8 opcode"}, op0, e0);
    check({tag, " R8 random fill"}, op1, e1);
    check({tag, " R6 is_push"}, push0, e0[8]);
    check({tag, " R6 push_imm"}, imm0, e0[8] ? e0[7:0] : 8'h00);
    check({tag, " R6 push_imm rnd"}, imm1, e1[8] ? e1[7:0] : 8'h00);
  endtask

  task automatic step(input string tag, input int a);
    pc = PCW'(a);
    @(negedge clk);
    check_all(tag, a);
  endtask

  initial begin
    #200000;
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    int seed_val;
    #1;
    check("R1 power-up", op0, 0);
    check("R1 power-up rnd", op1, 0);
    pc = 8'd10;
    @(negedge clk);
    check("R2 reset", op0, 0);
    check("R2 reset rnd", op1, 0);
    rst = 1'b0;
    for (int a = 0; a < 256; a++) step("sweep", a);
    step("R4 unmapped", 192);
    step("R4 unmapped top", 255);
    step("boundary 63", 63);
    step("boundary 64", 64);
    step("boundary 127", 127);
    step("boundary 128", 128);
    step("R8 end of program", PL - 1);
    step("R8 past program", PL);
    seed_val = $urandom(32'd4242);
    for (int k = 0; k < 400; k++) step("random", int'($urandom % 256));
    pc = 8'd5;
    @(negedge clk);
    check("R3 pre-reset", op0, exp_op(5, 1'b0));
    rst = 1'b1;
    pc = 8'd70;
    @(negedge clk);
    check("R2 mid-run reset", op0, 0);
    check("R2 mid-run reset rnd", op1, 0);
    rst = 1'b0;
    step("R3 after reset", 70);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule